// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a clocked host and an 8192-by-8 asynchronous static RAM. The host asks for one read or one write with a valid/ready handshake. The block then drives the chip-enable, write-enable and output-enable strobes, the address and the write-data bus with its driver enable. When the cycle finishes it returns a one-clock acknowledge. Every analog timing margin of the memory is a nanosecond parameter. Each margin is rounded up to whole clocks of a clock-period parameter, so the same RTL serves any clock rate.

A write-inhibit input comes from a supply supervisor. While it is high, every strobe is forced inactive at once and the data driver is released. A cycle that is running is cut short. A request that arrives while it is high is accepted and then refused. In both cases the acknowledge carries an error flag.

Reads hold chip enable and output enable low for the full access window. The data is captured on the last clock of that window and comes back with a one-clock valid pulse. Writes always end with write enable rising while chip enable is still low, which puts the hold and recovery margins at zero. The data driver stays on for one more clock after write enable rises.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, the strobe outputs `sram_ce_n`, `sram_we_n` and `sram_oe_n` are all 1, `sram_wdata_oe` is 0, `req_ready` is 1 and `ack` is 0.
- R2: A read holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for exactly ceil(max(access, read-cycle)/clock) clocks, which is 7 clocks at the defaults (10 ns clock, 70 ns).
- R3: Read data is sampled from `sram_rdata` on the last clock of the read window. It appears on `rd_data` together with a one-clock `rd_valid` pulse, in the same cycle as an `ack` that has `ack_err`=0. `rd_valid` never occurs without `ack`.
- R4: A write holds `sram_ce_n`=0, `sram_we_n`=0 and `sram_wdata_oe`=1 for exactly 6 clocks at the defaults. This is the largest of the rounded write-pulse, data-setup and (write-cycle minus one) margins. `sram_oe_n` stays 1 whenever `sram_we_n` is 0.
- R5: A write ends with `sram_we_n` rising while `sram_ce_n` stays 0 and `sram_wdata_oe` stays 1 for one more clock. The whole chip-enable period of a write is 7 clocks. Chip enable never rises before write enable.
- R6: `ack` is a one-clock pulse. In the ack cycle `req_ready` is 0 and all strobes are inactive. `req_ready` returns after the recovery count, which is 1 clock at the defaults.
- R7: If `wr_inhibit` rises during a cycle, all three strobes go to 1 and `sram_wdata_oe` goes to 0 in the same cycle. The next clock gives `ack` with `ack_err`=1 and no `rd_valid`. An aborted write leaves the stored byte unchanged.
- R8: A request accepted while `wr_inhibit` is 1 gets `ack` with `ack_err`=1 and asserts no strobe, so the addressed byte keeps its old value.
- R9: `sram_addr` and `sram_wdata` stay stable for as long as `sram_ce_n` is 0.
- R10: A request is taken only on a clock where `req_valid` and `req_ready` are both 1. A request held while the block is busy waits, and back-to-back requests are carried out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller can take a request |
| ack | output | 1 | One-clock completion pulse |
| ack_err | output | 1 | Cycle aborted or refused by write inhibit |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Captured read data |
| wr_inhibit | input | 1 | Supply supervisor write-inhibit |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 13 | Memory address |
| sram_wdata | output | 8 | Data driven toward memory |
| sram_wdata_oe | output | 1 | Enable of the write-data driver |
| sram_rdata | input | 8 | Data returned by memory |

## Verification
The bench model of the memory returns corrupted data until the output-enable window has lasted the full access time. A controller that samples read data a clock early therefore hands back wrong bytes. The model commits a write only after the full overlap, and only if the data driver is still on when write enable rises. A short pulse, or a driver released too early, leaves a stale byte, and a later read or the hold check shows it. Write inhibit is applied mid-read, mid-write and before a request. A design that lets a strobe linger, acknowledges without the error flag, or lets an aborted write land is caught by the port checks or by the read-back of the old byte. Back-to-back requests and a strobe-length count on every cycle expose wrong rounding of the clock counts and early return of ready.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_WEND,
        ST_REC
    } st_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    function automatic int clks(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(input st_e s);
        strobe_t r;
        r = STROBE_OFF;
        case (s)
            ST_READ:  begin r.ce_n = 1'b0; r.oe_n = 1'b0; end
            ST_WRITE: begin r.ce_n = 1'b0; r.we_n = 1'b0; r.drv = 1'b1; end
            ST_WEND:  begin r.ce_n = 1'b0; r.drv = 1'b1; end
            default:  r = STROBE_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
    import sramc_pkg::*;
#(
    parameter int RD_CLKS   = 7,
    parameter int WP_CLKS   = 6,
    parameter int WEND_CLKS = 1,
    parameter int REC_CLKS  = 1,
    parameter int W         = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic         inhibit,
    input  logic         tdone,
    output st_e          st_nxt,
    output logic         tload,
    output logic [W-1:0] tval,
    output logic         accept,
    output logic         capture,
    output logic         ready,
    output logic         ack,
    output logic         ack_err,
    output logic         rd_valid
);
    st_e  st;
    logic fin, err;

    always_comb begin
        st_nxt  = st;
        tload   = 1'b0;
        tval    = '0;
        accept  = 1'b0;
        capture = 1'b0;
        fin     = 1'b0;
        err     = 1'b0;
        case (st)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                tload  = 1'b1;
                if (inhibit) begin
                    st_nxt = ST_REC; fin = 1'b1; err = 1'b1; tval = W'(REC_CLKS - 1);
                end else if (req_write) begin
                    st_nxt = ST_WRITE; tval = W'(WP_CLKS - 1);
                end else begin
                    st_nxt = ST_READ; tval = W'(RD_CLKS - 1);
                end
            end
            ST_READ, ST_WRITE, ST_WEND: begin
                if (inhibit) begin
                    st_nxt = ST_REC; fin = 1'b1; err = 1'b1;
                    tload = 1'b1; tval = W'(REC_CLKS - 1);
                end else if (tdone) begin
                    tload = 1'b1;
                    if (st == ST_WRITE) begin
                        st_nxt = ST_WEND; tval = W'(WEND_CLKS - 1);
                    end else begin
                        st_nxt = ST_REC; fin = 1'b1; tval = W'(REC_CLKS - 1);
                        capture = (st == ST_READ);
                    end
                end
            end
            ST_REC: if (tdone) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ack      <= 1'b0;
            ack_err  <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            st       <= st_nxt;
            ack      <= fin;
            ack_err  <= err;
            rd_valid <= capture;
        end
    end

    assign ready = (st == ST_IDLE);

    AST_ABORT_ACKS_ERR: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_READ || st == ST_WRITE || st == ST_WEND) && inhibit) |=> (ack && ack_err)); // R7
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R6
    AST_ACK_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        ack |-> !ready); // R6
    AST_RDV_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (ack && !ack_err)); // R3

endmodule

// File: rtl/sramc_pins.sv
module sramc_pins
    import sramc_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  st_e           st_nxt,
    input  logic          accept,
    input  logic          capture,
    input  logic          inhibit,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] sram_rdata,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic          sram_wdata_oe,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_wdata,
    output logic [DW-1:0] rd_data
);
    strobe_t sq;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq         <= STROBE_OFF;
            sram_addr  <= '0;
            sram_wdata <= '0;
            rd_data    <= '0;
        end else begin
            sq <= strobes_for(st_nxt);
            if (accept) begin
                sram_addr  <= req_addr;
                sram_wdata <= req_wdata;
            end
            if (capture)
                rd_data <= sram_rdata;
        end
    end

    // supervisor inhibit overrides the registered strobes without a clock of delay
    assign sram_ce_n     = sq.ce_n | inhibit;
    assign sram_we_n     = sq.we_n | inhibit;
    assign sram_oe_n     = sq.oe_n | inhibit;
    assign sram_wdata_oe = sq.drv & ~inhibit;

    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> sram_oe_n); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_wdata))); // R9
    AST_DATA_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
        ($rose(sram_we_n) && !sram_ce_n) |-> sram_wdata_oe); // R5
    AST_CE_NOT_FIRST: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_ce_n); // R5

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sramc_pkg::*;
#(
    parameter int AW        = 13,
    parameter int DW        = 8,
    parameter int CLK_NS    = 10,
    parameter int T_ACC_NS  = 70,
    parameter int T_RC_NS   = 70,
    parameter int T_WP_NS   = 55,
    parameter int T_DS_NS   = 30,
    parameter int T_WC_NS   = 70,
    parameter int T_REC_NS  = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          ack,
    output logic          ack_err,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          wr_inhibit,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_wdata,
    output logic          sram_wdata_oe,
    input  logic [DW-1:0] sram_rdata
);
    localparam int RD_CLKS   = imax(clks(T_ACC_NS, CLK_NS), clks(T_RC_NS, CLK_NS));
    localparam int WEND_CLKS = 1;
    localparam int WP_CLKS   = imax(imax(clks(T_WP_NS, CLK_NS), clks(T_DS_NS, CLK_NS)),
                                    clks(T_WC_NS, CLK_NS) - WEND_CLKS);
    localparam int REC_CLKS  = imax(1, clks(T_REC_NS, CLK_NS));
    localparam int TW        = $clog2(imax(imax(RD_CLKS, WP_CLKS), REC_CLKS) + 1);

    st_e           st_nxt;
    logic          tload, tdone, accept, capture;
    logic [TW-1:0] tval;

    sramc_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tload),
        .load_val (tval),
        .done     (tdone)
    );

    sramc_fsm #(
        .RD_CLKS   (RD_CLKS),
        .WP_CLKS   (WP_CLKS),
        .WEND_CLKS (WEND_CLKS),
        .REC_CLKS  (REC_CLKS),
        .W         (TW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .inhibit   (wr_inhibit),
        .tdone     (tdone),
        .st_nxt    (st_nxt),
        .tload     (tload),
        .tval      (tval),
        .accept    (accept),
        .capture   (capture),
        .ready     (req_ready),
        .ack       (ack),
        .ack_err   (ack_err),
        .rd_valid  (rd_valid)
    );

    sramc_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk           (clk),
        .rst           (rst),
        .st_nxt        (st_nxt),
        .accept        (accept),
        .capture       (capture),
        .inhibit       (wr_inhibit),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .sram_rdata    (sram_rdata),
        .sram_ce_n     (sram_ce_n),
        .sram_we_n     (sram_we_n),
        .sram_oe_n     (sram_oe_n),
        .sram_wdata_oe (sram_wdata_oe),
        .sram_addr     (sram_addr),
        .sram_wdata    (sram_wdata),
        .rd_data       (rd_data)
    );

endmodule

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;
    localparam int RD_LEN = 7;
    localparam int WE_LEN = 6;
    localparam int CE_WR  = 7;
    localparam int ACC    = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, wr_inhibit = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, ack, ack_err, rd_valid;
    logic [7:0]  rd_data;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_wdata_oe;
    logic [12:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic [7:0]  sram_rdata = '0;

    always #5 clk = ~clk;

    sram_cycle_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .ack(ack), .ack_err(ack_err), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_inhibit(wr_inhibit), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_wdata_oe(sram_wdata_oe), .sram_rdata(sram_rdata)
    );

    typedef struct { bit rd; bit err; logic [7:0] d; } exp_t;
    exp_t q[$];

    logic [7:0] mem [8192];
    logic [7:0] shadow [8192];
    int checks = 0, fails = 0, acks = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // driver: pushes the expected outcome, then hands the request over
    task automatic op(input bit wr, input logic [12:0] a, input logic [7:0] d, input int abort_after);
        exp_t e;
        int n0;
        e.rd  = !wr;
        e.err = (abort_after != 0) || wr_inhibit;
        e.d   = shadow[a];
        if (wr && !e.err) shadow[a] = d;
        q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (abort_after > 0) begin
            n0 = acks;
            repeat (abort_after - 1) @(negedge clk);
            wr_inhibit = 1'b1;
            #1;
            check(sram_ce_n && sram_we_n && sram_oe_n && !sram_wdata_oe, "R7 strobes off at once",
                  {sram_ce_n, sram_we_n, sram_oe_n, sram_wdata_oe}, 4'b1110);
            while (acks == n0) @(negedge clk);
            wr_inhibit = 1'b0;
        end
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor and memory model, sampled away from the clock edge
    int ccnt = 0, wcnt = 0, rcnt = 0, racc = 0, wov = 0;
    bit abort_seen = 0, prev_ack = 0;
    logic [7:0]  wlat;
    logic [12:0] waddr;

    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (wr_inhibit)
                check(sram_ce_n && sram_we_n && sram_oe_n && !sram_wdata_oe, "R8 quiet under inhibit",
                      {sram_ce_n, sram_we_n, sram_oe_n, sram_wdata_oe}, 4'b1110);
            if (!sram_we_n) check(sram_oe_n, "R4 oe high in write", sram_oe_n, 1);
            if (!sram_we_n) check(!sram_ce_n, "R5 ce not before we", sram_ce_n, 0);
            if (wr_inhibit) abort_seen = 1;
            // strobe run lengths
            if (!sram_ce_n) begin
                ccnt++;
                if (!sram_we_n) wcnt++;
                if (!sram_oe_n) rcnt++;
            end else if (ccnt != 0) begin
                if (!abort_seen) begin
                    if (wcnt != 0) begin
                        check(wcnt == WE_LEN, "R4 we low length", wcnt, WE_LEN);
                        check(ccnt == CE_WR, "R5 ce low length in write", ccnt, CE_WR);
                    end else
                        check(rcnt == RD_LEN, "R2 read window length", rcnt, RD_LEN);
                end
                ccnt = 0; wcnt = 0; rcnt = 0; abort_seen = 0;
            end
            // memory model
            if (!sram_ce_n && !sram_oe_n && sram_we_n) racc++; else racc = 0;
            sram_rdata <= (racc >= ACC) ? mem[sram_addr] : ~mem[sram_addr];
            if (!sram_ce_n && !sram_we_n) begin
                wov++;
                if (sram_wdata_oe) wlat = sram_wdata;
                waddr = sram_addr;
            end else if (wov != 0) begin
                if (wov >= WE_LEN) begin
                    check(!sram_ce_n && sram_wdata_oe, "R5 data held after we rises",
                          {sram_ce_n, sram_wdata_oe}, 2'b01);
                    if (!sram_ce_n && sram_wdata_oe) mem[waddr] = wlat;
                end
                wov = 0;
            end
            // scoreboard
            if (rd_valid && !ack) check(0, "R3 rd_valid without ack", 1, 0);
            if (prev_ack) check(req_ready, "R6 ready after recovery", req_ready, 1);
            if (ack) begin
                exp_t e;
                check(!req_ready && sram_ce_n && sram_we_n && sram_oe_n, "R6 ack cycle idle",
                      {req_ready, sram_ce_n, sram_we_n, sram_oe_n}, 4'b0111);
                if (q.size() == 0) check(0, "R10 unexpected ack", 1, 0);
                else begin
                    e = q.pop_front();
                    check(ack_err == e.err, "R7 ack error flag", ack_err, e.err);
                    if (e.err) check(!rd_valid, "R7 no rd_valid on abort", rd_valid, 0);
                    else if (e.rd) begin
                        check(rd_valid, "R3 rd_valid pulse", rd_valid, 1);
                        check(rd_data == e.d, "R3 read data", rd_data, e.d);
                    end
                end
                acks++;
            end
            prev_ack = ack;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 8192; i++) begin
            mem[i]    = 8'(i) ^ {i[12:8], 3'b101};
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #3;
        check(sram_ce_n && sram_we_n && sram_oe_n && !sram_wdata_oe && req_ready && !ack,
              "R1 reset state", {sram_ce_n, sram_we_n, sram_oe_n, sram_wdata_oe, req_ready, ack},
              6'b111010);

        // basic writes and reads at both address ends (R2 R3 R4 R5)
        op(1, 13'h0000, 8'h3C, 0); wait_idle();
        op(0, 13'h0000, 8'h00, 0); wait_idle();
        op(1, 13'h1FFF, 8'hC3, 0); wait_idle();
        op(0, 13'h1FFF, 8'h00, 0); wait_idle();
        op(0, 13'h0123, 8'h00, 0); wait_idle();

        // back-to-back requests held while busy (R10 R9)
        op(1, 13'h0AAA, 8'h55, 0);
        op(1, 13'h1555, 8'hAA, 0);
        op(0, 13'h0AAA, 8'h00, 0);
        op(0, 13'h1555, 8'h00, 0);
        op(1, 13'h0AAA, 8'h0F, 0);
        op(0, 13'h0AAA, 8'h00, 0);
        wait_idle();

        // inhibit mid-read and mid-write (R7)
        op(0, 13'h0123, 8'h00, 3); wait_idle();
        op(1, 13'h0AAA, 8'hEE, 2); wait_idle();
        op(0, 13'h0AAA, 8'h00, 0); wait_idle();
        op(1, 13'h1555, 8'h99, 6); wait_idle();
        op(0, 13'h1555, 8'h00, 0); wait_idle();

        // request arriving under inhibit is refused (R8)
        begin
            int n0;
            wr_inhibit = 1'b1;
            n0 = acks;
            op(1, 13'h0000, 8'h77, 0);
            while (acks == n0) @(negedge clk);
            wr_inhibit = 1'b0;
        end
        wait_idle();
        op(0, 13'h0000, 8'h00, 0); wait_idle();

        done = 1;
        finish_run();
    end

endmodule